// File: doc/BRIEF.md
# Hold-Off Triggered Ramp Address Sequencer

This block sequences one channel's time-slot ramp. A trigger pulse loads a hold-off counter with a programmed start count. Once the trigger is low, the counter counts down by one on each clock. When it reaches one, the block walks the ramp-memory read address down from the last coefficient index to zero. It then holds for an optional programmed number of rest clocks, and walks the address from zero back up to the last index. After the final ascending address it emits a single-cycle completion pulse and returns to idle.

The ramp-memory contents and the multiply that applies each coefficient lie outside the block. A consumer reads memory at `ram_addr` while `ramp_active` is high. The configuration inputs `load_count`, `ramp_last` and `rest_len` must stay stable from the trigger until the completion pulse.

Top module: `holdoff_ramp_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ramp_active` and `done` are 0 and `ram_addr` is 0.
- R2: A trigger sampled high in idle loads the hold-off counter with `load_count`. With count C ≥ 2, `ramp_active` first rises after the C-th rising clock edge at which the trigger is sampled low.
- R3: While the trigger stays high, the counter reloads on every clock. The delay from trigger release to ramp start therefore does not depend on how long the trigger was held.
- R4: With `load_count` of 0 or 1, `ramp_active` rises after the first clock edge at which the trigger is sampled low.
- R5: The descending ramp presents `ram_addr` = `ramp_last`, `ramp_last`-1, …, 0, one value per clock, with `ramp_active` high.
- R6: With `rest_len` = N > 0, `ramp_active` is low for exactly N clocks between the descending and ascending ramps.
- R7: With `rest_len` = 0, the ascending ramp begins on the clock right after the descending ramp's address 0.
- R8: The ascending ramp presents `ram_addr` = 0, 1, …, `ramp_last`, one value per clock, with `ramp_active` high. Address 0 is presented once at the end of the descent and again at the start of the ascent.
- R9: `done` is high for exactly one cycle, the cycle after the last ascending address, with `ramp_active` low.
- R10: A trigger that arrives during either ramp or the rest has no effect. No new hold-off starts, and the sequence in progress is unchanged.
- R11: With `ramp_last` = 0, each ramp lasts a single cycle at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Sync trigger, high for one or more clocks |
| load_count | input | CNT_W | Hold-off start count |
| ramp_last | input | ADDR_W | Index of last ramp coefficient |
| rest_len | input | REST_W | Rest length in clocks between ramps, 0 = none |
| ram_addr | output | ADDR_W | Ramp-memory read address |
| ramp_active | output | 1 | High while a ramp address is presented |
| done | output | 1 | One-cycle pulse after the ascending ramp |

## Verification
A wrong hold-off count shows at the ports as a ramp that starts one or more cycles early or late after trigger release. The per-cycle comparison catches it on the first cycle where `ramp_active` differs. A corrupted address stepper or a bad phase transition shows up within one clock as a wrong `ram_addr`, a misplaced gap in `ramp_active`, or a missing or doubled `done`. An FSM that does not ignore triggers mid-sequence restarts the hold-off. That shows up as `ramp_active` dropping early and `done` never arriving where the reference expects it.

// File: rtl/hors_pkg.sv
// Shared types for the hold-off ramp sequencer.
package hors_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_DOWN,
        PH_REST,
        PH_UP
    } phase_e;
endpackage

// File: rtl/hors_downcnt.sv
// Loadable down-counter used for the hold-off count and the rest timer.
// Assumes: load has priority over run; the counter stops at one and
// at_one is high whenever the count is one or zero.
module hors_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         at_one
);
    logic [W-1:0] cnt;

    // Load, or step toward one while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt > W'(1))
            cnt <= cnt - W'(1);
    end

    assign at_one = (cnt <= W'(1));
endmodule

// File: rtl/hors_addr.sv
// Ramp-memory address register with preset, clear and +/-1 steps.
// Assumes: at most one control is high per cycle; priority is
// set_top, clr, step_dn, step_up.
module hors_addr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_top,
    input  logic [W-1:0] top_val,
    input  logic         clr,
    input  logic         step_dn,
    input  logic         step_up,
    output logic [W-1:0] addr
);
    // Update the address according to the active control.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (set_top)
            addr <= top_val;
        else if (clr)
            addr <= '0;
        else if (step_dn)
            addr <= addr - W'(1);
        else if (step_up)
            addr <= addr + W'(1);
    end
endmodule

// File: rtl/holdoff_ramp_seq.sv
// Top: trigger-loaded hold-off countdown followed by a descending ramp,
// an optional rest and an ascending ramp over ramp-memory addresses.
// Assumes: load_count, ramp_last and rest_len are stable from the
// trigger until done; triggers outside idle/hold are ignored.
module holdoff_ramp_seq #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 6,
    parameter int REST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [CNT_W-1:0]  load_count,
    input  logic [ADDR_W-1:0] ramp_last,
    input  logic [REST_W-1:0] rest_len,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ramp_active,
    output logic              done
);
    import hors_pkg::*;

    phase_e phase_q, phase_d;
    logic hold_load, hold_run, hold_exp;
    logic rest_load, rest_exp;
    logic a_set, a_clr, a_dn, a_up;
    logic done_set;
    logic addr_zero, addr_top;

    assign addr_zero = (ram_addr == '0);
    assign addr_top  = (ram_addr == ramp_last);

    hors_downcnt #(.W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(hold_load), .load_val(load_count),
        .run(hold_run), .at_one(hold_exp)
    );

    hors_downcnt #(.W(REST_W)) u_rest (
        .clk(clk), .rst_n(rst_n), .load(rest_load), .load_val(rest_len),
        .run(phase_q == PH_REST), .at_one(rest_exp)
    );

    hors_addr #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .set_top(a_set), .top_val(ramp_last),
        .clr(a_clr), .step_dn(a_dn), .step_up(a_up), .addr(ram_addr)
    );

    // Next phase and datapath controls.
    always_comb begin
        phase_d   = phase_q;
        hold_load = 1'b0;
        hold_run  = 1'b0;
        rest_load = 1'b0;
        a_set     = 1'b0;
        a_clr     = 1'b0;
        a_dn      = 1'b0;
        a_up      = 1'b0;
        done_set  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (trig) begin
                    hold_load = 1'b1;
                    phase_d   = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (trig) begin
                    hold_load = 1'b1;
                end else if (hold_exp) begin
                    a_set   = 1'b1;
                    phase_d = PH_DOWN;
                end else begin
                    hold_run = 1'b1;
                end
            end
            PH_DOWN: begin
                if (!addr_zero) begin
                    a_dn = 1'b1;
                end else if (rest_len == '0) begin
                    a_clr   = 1'b1;
                    phase_d = PH_UP;
                end else begin
                    rest_load = 1'b1;
                    phase_d   = PH_REST;
                end
            end
            PH_REST: begin
                if (rest_exp) begin
                    a_clr   = 1'b1;
                    phase_d = PH_UP;
                end
            end
            PH_UP: begin
                if (addr_top) begin
                    done_set = 1'b1;
                    phase_d  = PH_IDLE;
                end else begin
                    a_up = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register and registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done    <= done_set;
        end
    end

    assign ramp_active = (phase_q == PH_DOWN) || (phase_q == PH_UP);
endmodule

// File: rtl/hors_chk.sv
// Protocol checker for holdoff_ramp_seq, attached by bind.
module hors_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic [ADDR_W-1:0] ramp_last,
    input hors_pkg::phase_e  phase,
    input logic [ADDR_W-1:0] addr,
    input logic              ramp_active,
    input logic              done
);
    import hors_pkg::*;

    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DOWN && addr != '0) |=> (addr == $past(addr) - 1'b1));

    // R8
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_UP && addr != ramp_last) |=> (addr == $past(addr) + 1'b1));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ramp_active);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_DOWN || phase == PH_REST || phase == PH_UP) && trig)
        |=> (phase != PH_HOLD));

    // R3
    hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && trig) |=> (phase == PH_HOLD));
endmodule

bind holdoff_ramp_seq hors_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ramp_last(ramp_last),
    .phase(phase_q), .addr(ram_addr), .ramp_active(ramp_active), .done(done)
);

// File: tb/sim_holdoff_ramp_seq.sv
module sim_holdoff_ramp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 6;
    localparam int REST_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic [CNT_W-1:0]  load_count = '0;
    logic [ADDR_W-1:0] ramp_last = '0;
    logic [REST_W-1:0] rest_len = '0;
    logic [ADDR_W-1:0] ram_addr;
    logic ramp_active, done;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    holdoff_ramp_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .REST_W(REST_W)) u0 (
        .clk(clk), .rst_n(rst_n), .trig(trig), .load_count(load_count),
        .ramp_last(ramp_last), .rest_len(rest_len), .ram_addr(ram_addr),
        .ramp_active(ramp_active), .done(done)
    );

    // Behavioural reference: a queue of expected per-cycle outputs.
    int    q_act[$];
    int    q_addr[$];
    int    q_done[$];
    string q_tag[$];
    bit    holding = 0;
    int    e_act = 0, e_addr = 0, e_done = 0;
    string e_tag = "R1";

    task automatic push(int a, int ad, int d, string t);
        q_act.push_back(a); q_addr.push_back(ad);
        q_done.push_back(d); q_tag.push_back(t);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q_act.delete(); q_addr.delete(); q_done.delete(); q_tag.delete();
            holding = 0; e_act = 0; e_addr = 0; e_done = 0; e_tag = "R1";
        end else begin
            if (q_act.size() == 0) begin
                if (holding) begin
                    if (!trig) begin
                        int n;
                        int last;
                        n = (int'(load_count) <= 1) ? 1 : int'(load_count);
                        last = int'(ramp_last);
                        for (int i = 0; i < n - 1; i++) push(0, 0, 0, "R2");
                        for (int a = last; a >= 0; a--)
                            push(1, a, 0, (last == 0) ? "R11" : "R5");
                        for (int i = 0; i < int'(rest_len); i++) push(0, 0, 0, "R6");
                        for (int a = 0; a <= last; a++)
                            push(1, a, 0, (a == 0 && rest_len == 0) ? "R7" : "R8");
                        push(0, 0, 1, "R9");
                        holding = 0;
                    end
                end else if (trig) begin
                    holding = 1;
                end
            end
            if (q_act.size() > 0) begin
                e_act = q_act.pop_front(); e_addr = q_addr.pop_front();
                e_done = q_done.pop_front(); e_tag = q_tag.pop_front();
            end else begin
                e_act = 0; e_done = 0; e_tag = holding ? "R3" : "R10";
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (ramp_active !== e_act[0]) begin
                fails++;
                $display("FAIL %s ramp_active actual=%0b expected=%0d t=%0t", e_tag, ramp_active, e_act, $time);
            end
            checks++;
            if (done !== e_done[0]) begin
                fails++;
                $display("FAIL %s done actual=%0b expected=%0d t=%0t", e_tag, done, e_done, $time);
            end
            if (e_act != 0) begin
                checks++;
                if (int'(ram_addr) != e_addr) begin
                    fails++;
                    $display("FAIL %s ram_addr actual=%0d expected=%0d t=%0t", e_tag, ram_addr, e_addr, $time);
                end
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One trigger and full sequence; measures release-to-ramp latency.
    task automatic run_seq(int c, int last, int rest, int hold_cyc, bit pulse, string tag);
        int lat;
        int exp_lat;
        load_count = CNT_W'(c); ramp_last = ADDR_W'(last); rest_len = REST_W'(rest);
        trig = 1'b1;
        repeat (hold_cyc) @(negedge clk);
        trig = 1'b0;
        lat = 0;
        while (!ramp_active && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = (c <= 1) ? 1 : c;
        check(lat == exp_lat, tag, lat, exp_lat);
        while (!done) begin
            @(negedge clk);
            trig = pulse ? ~trig : 1'b0;   // R10 stimulus when pulse is set
        end
        trig = 1'b0;
        repeat (3) @(negedge clk);
        check(!ramp_active && !done, "R10 idle after done", int'(ramp_active), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!ramp_active && !done && ram_addr == '0, "R1", int'(ram_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ramp_active && !done && ram_addr == '0, "R1", int'(ramp_active), 0);
        repeat (2) @(negedge clk);
        run_seq(5, 3, 4, 1, 0, "R2");
        run_seq(5, 3, 4, 4, 0, "R3");
        run_seq(0, 4, 0, 1, 0, "R4");
        run_seq(1, 2, 0, 2, 0, "R4");
        run_seq(1, 0, 2, 1, 0, "R11");
        run_seq(3, 5, 3, 1, 1, "R10");
        run_seq(7, 63, 1, 1, 0, "R2");
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule